// File: doc/BRIEF.md
# Injected Conversion Sequencer

This block runs the high-priority ("injected") conversion group of a multi-channel analog-to-digital controller. It holds a short table of rank slots. Each slot names the channel to convert and an offset that is removed from that channel's raw sample. When a start event arrives, the block requests conversions from an abstract converter one rank at a time. It waits for the converter's done pulse before it moves to the next rank, stores an offset-corrected signed result per rank, and signals the end of the sequence.

A start event is one of three things: a software start pulse, a selected edge of an asynchronous external trigger line, or the end of the regular group's sequence when automatic chaining is enabled. The sequence can cover the whole programmed length (scan), only the first rank, or one rank per start event (discontinuous stepping, with wrap-around). The register bus, the analog converter and any data movers are outside this block. Configuration arrives as plain input levels.

Top module: `adc_inject_sequencer`

## Requirements
- R1: After reset `conv_req`, `eos` and `busy` are 0 and every rank result reads 0.
- R2: With `cfg_scan`=1, one start converts ranks 0 up to `cfg_len` (length minus one, so 0..3 gives 1..4 ranks) in ascending order. Each rank gives exactly one single-cycle `conv_req` pulse, and the next request comes only after `conv_done`. `conv_chan` carries the rank's channel field, which for rank i is `cfg_chan[i*CH_W +: CH_W]`.
- R3: With `cfg_scan`=0, each start converts rank 0 only, whatever `cfg_len` holds.
- R4: When `cfg_scan`=1, `cfg_cont`=0 and `cfg_disc`=1, each start converts one rank. The rank advances by one per start and wraps to rank 0 after rank `cfg_len`. `eos` pulses only when rank `cfg_len` completes.
- R5: `cfg_disc` has no effect when `cfg_scan`=0 or `cfg_cont`=1. In those cases the sequence behaves as in R2 or R3.
- R6: With `cfg_sw_sel`=0, `cfg_edge` chooses the external start: 00 none, 01 rising, 10 falling, 11 both. The trigger passes through two synchronising flops, so `conv_req` first rises in the cycle after the third rising clock edge that follows a change of `ext_trig`.
- R7: With `cfg_sw_sel`=1 the external line and `cfg_edge` are ignored. `sw_start` starts a sequence whatever `cfg_sw_sel` holds.
- R8: A `reg_done` pulse starts a sequence only when `cfg_auto`=1, `cfg_sw_sel`=1 and `cfg_disc`=0. If `reg_done` and `sw_start` fall in the same cycle, exactly one sequence runs.
- R9: The result of rank i is the (RES_W+1)-bit two's-complement value of raw sample minus `cfg_offs[i*RES_W +: RES_W]`. It is placed at `res_flat[i*(RES_W+1) +: RES_W+1]`, so a sample below the offset reads negative.
- R10: `eos` is a one-cycle pulse in the first cycle in which the last rank's result is visible. Ranks not converted in a sequence keep their previous results.
- R11: A start event that arrives while `busy`=1 is ignored. `busy` is high from the cycle after a start is accepted until the `eos` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Sequence length minus one |
| cfg_scan | input | 1 | Scan the whole length |
| cfg_cont | input | 1 | Continuous mode (blocks discontinuous stepping) |
| cfg_disc | input | 1 | Discontinuous one-rank-per-start stepping |
| cfg_auto | input | 1 | Chain after the regular group end |
| cfg_sw_sel | input | 1 | Software start only; external trigger disabled |
| cfg_edge | input | 2 | External trigger edge code |
| cfg_chan | input | 20 | Channel number per rank, 5 bits each |
| cfg_offs | input | 48 | Offset per rank, 12 bits each |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | Asynchronous external trigger line |
| reg_done | input | 1 | Regular group sequence finished pulse |
| conv_req | output | 1 | Single-cycle conversion request |
| conv_chan | output | 5 | Channel for the current request |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 12 | Raw converter sample, valid with conv_done |
| res_flat | output | 52 | Signed result per rank, 13 bits each |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | Sequence in progress |

## Verification
Two start sources can land on the same clock edge. The first case is the automatic chain start and a software start: the bench raises `reg_done` and `sw_start` together with chaining enabled and requires exactly one burst of requests and one `eos`. The second case is a fresh start arriving while a sequence is still running: the bench pulses `sw_start` in the middle of a four-rank run and requires the request count and the `eos` count to stay those of a single run.

// File: rtl/injseq_pkg.sv
package injseq_pkg;

    // Sequencer states: idle, issue one request, wait for the converter
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    // Edge selection codes
    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;

endpackage

// File: rtl/injseq_trig.sv
module injseq_trig (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_trig,
    input  logic       cfg_sw_sel,
    input  logic [1:0] cfg_edge,
    output logic       ext_evt
);
    import injseq_pkg::*;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  rise, fall;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = ext_trig;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise    = sync_q.s2 & ~sync_q.s3;
    assign fall    = ~sync_q.s2 & sync_q.s3;
    assign ext_evt = ~cfg_sw_sel &
                     (((cfg_edge & EDGE_RISE) != EDGE_NONE && rise) ||
                      ((cfg_edge & EDGE_FALL) != EDGE_NONE && fall));

    // R6
    // a detected edge always follows a synchroniser change one cycle earlier
    evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |-> $past(sync_q.s1) != $past(sync_q.s2));

endmodule

// File: rtl/injseq_fsm.sv
module injseq_fsm #(
    parameter int NRANK = 4,
    parameter int CH_W  = 5,
    localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RK_W-1:0]       cfg_len,
    input  logic                  cfg_scan,
    input  logic                  cfg_cont,
    input  logic                  cfg_disc,
    input  logic                  cfg_auto,
    input  logic                  cfg_sw_sel,
    input  logic [NRANK*CH_W-1:0] cfg_chan,
    input  logic                  sw_start,
    input  logic                  ext_evt,
    input  logic                  reg_done,
    input  logic                  conv_done,
    output logic                  conv_req,
    output logic [CH_W-1:0]       conv_chan,
    output logic                  wr_en,
    output logic [RK_W-1:0]       wr_idx,
    output logic                  busy,
    output logic                  eos
);
    import injseq_pkg::*;

    typedef struct packed {
        seq_state_e      state;
        logic [RK_W-1:0] rank;
        logic [RK_W-1:0] last;
        logic [RK_W-1:0] ptr;
        logic            step_run;
        logic            eos;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic            step_mode;
    logic            chain_ok;
    logic            start_evt;
    logic [RK_W-1:0] step_first;

    assign step_mode  = cfg_scan & ~cfg_cont & cfg_disc;
    assign chain_ok   = cfg_auto & cfg_sw_sel & ~cfg_disc;
    assign start_evt  = sw_start | ext_evt | (chain_ok & reg_done);
    assign step_first = (fsm_q.ptr > cfg_len) ? '0 : fsm_q.ptr;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.eos = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (start_evt) begin
                    fsm_d.state = ST_ISSUE;
                    if (step_mode) begin
                        fsm_d.rank     = step_first;
                        fsm_d.last     = step_first;
                        fsm_d.step_run = 1'b1;
                    end else begin
                        fsm_d.rank     = '0;
                        fsm_d.last     = cfg_scan ? cfg_len : '0;
                        fsm_d.step_run = 1'b0;
                    end
                end
            end
            ST_ISSUE: begin
                fsm_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (fsm_q.rank == fsm_q.last) begin
                        fsm_d.state = ST_IDLE;
                        if (fsm_q.step_run) begin
                            fsm_d.ptr = (fsm_q.rank >= cfg_len) ? '0 : fsm_q.rank + 1'b1;
                            fsm_d.eos = (fsm_q.rank >= cfg_len);
                        end else begin
                            fsm_d.ptr = '0;
                            fsm_d.eos = 1'b1;
                        end
                    end else begin
                        fsm_d.rank  = fsm_q.rank + 1'b1;
                        fsm_d.state = ST_ISSUE;
                    end
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign conv_req  = (fsm_q.state == ST_ISSUE);
    assign conv_chan = cfg_chan[fsm_q.rank*CH_W +: CH_W];
    assign wr_en     = (fsm_q.state == ST_WAIT) && conv_done;
    assign wr_idx    = fsm_q.rank;
    assign busy      = (fsm_q.state != ST_IDLE);
    assign eos       = fsm_q.eos;

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT && !conv_done) |=>
            (fsm_q.state == ST_WAIT && $stable(fsm_q.rank)));

    // R4
    rank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> fsm_q.rank <= fsm_q.last);

    // R11
    eos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> !busy);

endmodule

// File: rtl/injseq_results.sv
module injseq_results #(
    parameter int NRANK = 4,
    parameter int RES_W = 12,
    localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
    localparam int OUT_W = RES_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RK_W-1:0]         wr_idx,
    input  logic [RES_W-1:0]        conv_data,
    input  logic [NRANK*RES_W-1:0]  cfg_offs,
    output logic [NRANK*OUT_W-1:0]  res_flat
);

    typedef struct packed {
        logic [NRANK-1:0][OUT_W-1:0] val;
    } res_t;

    res_t             res_d, res_q;
    logic [RES_W-1:0] off_sel;
    logic [OUT_W-1:0] diff;

    assign off_sel = cfg_offs[wr_idx*RES_W +: RES_W];
    assign diff    = {1'b0, conv_data} - {1'b0, off_sel};

    always_comb begin
        res_d = res_q;
        if (wr_en) res_d.val[wr_idx] = diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    for (genvar gi = 0; gi < NRANK; gi++) begin : g_out
        assign res_flat[gi*OUT_W +: OUT_W] = res_q.val[gi];
    end

    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(res_flat));

endmodule

// File: rtl/adc_inject_sequencer.sv
module adc_inject_sequencer #(
    parameter int NRANK = 4,
    parameter int CH_W  = 5,
    parameter int RES_W = 12,
    localparam int RK_W = (NRANK > 1) ? $clog2(NRANK) : 1,
    localparam int OUT_W = RES_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RK_W-1:0]        cfg_len,
    input  logic                   cfg_scan,
    input  logic                   cfg_cont,
    input  logic                   cfg_disc,
    input  logic                   cfg_auto,
    input  logic                   cfg_sw_sel,
    input  logic [1:0]             cfg_edge,
    input  logic [NRANK*CH_W-1:0]  cfg_chan,
    input  logic [NRANK*RES_W-1:0] cfg_offs,
    input  logic                   sw_start,
    input  logic                   ext_trig,
    input  logic                   reg_done,
    output logic                   conv_req,
    output logic [CH_W-1:0]        conv_chan,
    input  logic                   conv_done,
    input  logic [RES_W-1:0]       conv_data,
    output logic [NRANK*OUT_W-1:0] res_flat,
    output logic                   eos,
    output logic                   busy
);

    logic            ext_evt;
    logic            wr_en;
    logic [RK_W-1:0] wr_idx;

    injseq_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_trig   (ext_trig),
        .cfg_sw_sel (cfg_sw_sel),
        .cfg_edge   (cfg_edge),
        .ext_evt    (ext_evt)
    );

    injseq_fsm #(.NRANK(NRANK), .CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_len    (cfg_len),
        .cfg_scan   (cfg_scan),
        .cfg_cont   (cfg_cont),
        .cfg_disc   (cfg_disc),
        .cfg_auto   (cfg_auto),
        .cfg_sw_sel (cfg_sw_sel),
        .cfg_chan   (cfg_chan),
        .sw_start   (sw_start),
        .ext_evt    (ext_evt),
        .reg_done   (reg_done),
        .conv_done  (conv_done),
        .conv_req   (conv_req),
        .conv_chan  (conv_chan),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .busy       (busy),
        .eos        (eos)
    );

    injseq_results #(.NRANK(NRANK), .RES_W(RES_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .conv_data (conv_data),
        .cfg_offs  (cfg_offs),
        .res_flat  (res_flat)
    );

    // R10
    eos_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> $past(conv_done));

endmodule

// File: tb/adc_inject_sequencer_bench.sv
module adc_inject_sequencer_bench;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_len = '0;
    logic        cfg_scan = 1'b0, cfg_cont = 1'b0, cfg_disc = 1'b0;
    logic        cfg_auto = 1'b0, cfg_sw_sel = 1'b1;
    logic [1:0]  cfg_edge = '0;
    logic [19:0] cfg_chan;
    logic [47:0] cfg_offs;
    logic        sw_start = 1'b0, ext_trig = 1'b0, reg_done = 1'b0;
    logic        conv_req;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [51:0] res_flat;
    logic        eos, busy;

    int checks = 0, fails = 0;
    int salt = 0;
    int ch  [4] = '{3, 17, 30, 9};
    int off [4] = '{100, 3000, 0, 4095};
    int exp_res [4] = '{0, 0, 0, 0};
    int req_cnt = 0, eos_cnt = 0, lat_cnt = 0;
    int chan_hold = 0;
    int req_log [512];
    bit finished = 0;

    adc_inject_sequencer u_adc_inject_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_scan(cfg_scan),
        .cfg_cont(cfg_cont), .cfg_disc(cfg_disc), .cfg_auto(cfg_auto),
        .cfg_sw_sel(cfg_sw_sel), .cfg_edge(cfg_edge), .cfg_chan(cfg_chan),
        .cfg_offs(cfg_offs), .sw_start(sw_start), .ext_trig(ext_trig),
        .reg_done(reg_done), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .res_flat(res_flat),
        .eos(eos), .busy(busy)
    );

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            cfg_chan[i*5 +: 5]   = 5'(ch[i]);
            cfg_offs[i*12 +: 12] = 12'(off[i]);
        end
    end

    function automatic int model(int c, int s);
        return (c * 211 + s) % 4096;
    endfunction

    // converter model and event counters
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (lat_cnt == 1) begin
            conv_done <= 1'b1;
            conv_data <= 12'(model(chan_hold, salt));
        end
        if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
        if (conv_req) begin
            lat_cnt   <= LAT;
            chan_hold <= int'(conv_chan);
            req_log[req_cnt % 512] <= int'(conv_chan);
            req_cnt   <= req_cnt + 1;
        end
        if (eos) eos_cnt <= eos_cnt + 1;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int get_res(int i);
        return int'($signed(res_flat[i*13 +: 13]));
    endfunction

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 0;
    endtask

    task automatic check_all_res(string req);
        for (int i = 0; i < 4; i++) chk(req, get_res(i), exp_res[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int b, e, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'(conv_req), 0);
        chk("R1", int'(eos), 0);
        chk("R1", int'(busy), 0);
        check_all_res("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R9 R10: sweep scan and length
        for (int sc = 0; sc < 2; sc++) begin
            for (int ln = 0; ln < 4; ln++) begin
                salt = 1000 + sc * 517 + ln * 1231;
                cfg_scan = sc[0];
                cfg_len  = ln[1:0];
                b = req_cnt; e = eos_cnt;
                pulse_sw();
                settle();
                n = sc ? ln + 1 : 1;
                chk(sc ? "R2" : "R3", req_cnt - b, n);
                for (int i = 0; i < n; i++) begin
                    chk("R2", req_log[(b + i) % 512], ch[i]);
                    exp_res[i] = model(ch[i], salt) - off[i];
                end
                chk("R10", eos_cnt - e, 1);
                check_all_res("R9");
            end
        end

        // R11: second start while busy is ignored
        cfg_scan = 1; cfg_len = 2'd3; salt = 77;
        b = req_cnt; e = eos_cnt;
        pulse_sw();
        repeat (5) @(negedge clk);
        pulse_sw();
        settle();
        chk("R11", req_cnt - b, 4);
        chk("R11", eos_cnt - e, 1);
        for (int i = 0; i < 4; i++) exp_res[i] = model(ch[i], salt) - off[i];
        check_all_res("R11");

        // R4: discontinuous stepping with wrap
        cfg_scan = 1; cfg_cont = 0; cfg_disc = 1; cfg_len = 2'd2;
        for (int k = 0; k < 4; k++) begin
            salt = 300 + k * 41;
            b = req_cnt; e = eos_cnt;
            pulse_sw();
            settle();
            chk("R4", req_cnt - b, 1);
            chk("R4", req_log[b % 512], ch[k % 3]);
            chk("R4", eos_cnt - e, (k % 3 == 2) ? 1 : 0);
            exp_res[k % 3] = model(ch[k % 3], salt) - off[k % 3];
            check_all_res("R4");
        end

        // R5: discontinuous ignored with continuous on
        cfg_cont = 1; salt = 2024;
        b = req_cnt; e = eos_cnt;
        pulse_sw();
        settle();
        chk("R5", req_cnt - b, 3);
        chk("R5", eos_cnt - e, 1);
        for (int i = 0; i < 3; i++) exp_res[i] = model(ch[i], salt) - off[i];
        check_all_res("R5");

        // R5: discontinuous ignored without scan
        cfg_cont = 0; cfg_scan = 0;
        for (int k = 0; k < 2; k++) begin
            b = req_cnt; e = eos_cnt;
            pulse_sw();
            settle();
            chk("R5", req_cnt - b, 1);
            chk("R5", req_log[b % 512], ch[0]);
            chk("R5", eos_cnt - e, 1);
        end
        cfg_disc = 0;

        // R6: synchroniser latency
        cfg_sw_sel = 0; cfg_edge = 2'b01; cfg_scan = 0;
        b = req_cnt; e = eos_cnt;
        @(negedge clk) ext_trig = 1'b1;
        n = 0;
        for (int t = 0; t < 10; t++) begin
            @(posedge clk); #1;
            n++;
            if (conv_req) break;
        end
        chk("R6", n, 3);
        settle();
        @(negedge clk) ext_trig = 1'b0;
        settle();
        chk("R6", eos_cnt - e, 1);

        // R6: edge code sweep; R7: software selection masks the line
        for (int code = 0; code < 5; code++) begin
            cfg_sw_sel = (code == 4);
            cfg_edge   = (code == 4) ? 2'b11 : code[1:0];
            e = eos_cnt;
            @(negedge clk) ext_trig = 1'b1;
            settle();
            @(negedge clk) ext_trig = 1'b0;
            settle();
            chk(code == 4 ? "R7" : "R6", eos_cnt - e,
                (code == 3) ? 2 : ((code == 1 || code == 2) ? 1 : 0));
        end

        // R7: software start works with external selection active
        cfg_sw_sel = 0; cfg_edge = 2'b01;
        e = eos_cnt;
        pulse_sw();
        settle();
        chk("R7", eos_cnt - e, 1);

        // R8: automatic chaining
        cfg_sw_sel = 1; cfg_edge = 2'b00; cfg_auto = 1; cfg_scan = 1; cfg_len = 2'd1;
        b = req_cnt; e = eos_cnt;
        @(negedge clk) reg_done = 1'b1;
        @(negedge clk) reg_done = 1'b0;
        settle();
        chk("R8", req_cnt - b, 2);
        chk("R8", eos_cnt - e, 1);
        // R8: chain start and software start on the same edge
        b = req_cnt; e = eos_cnt;
        @(negedge clk) begin reg_done = 1'b1; sw_start = 1'b1; end
        @(negedge clk) begin reg_done = 1'b0; sw_start = 1'b0; end
        settle();
        chk("R8", req_cnt - b, 2);
        chk("R8", eos_cnt - e, 1);
        // R8: blocked by discontinuous bit, by external selection, by auto off
        for (int m = 0; m < 3; m++) begin
            cfg_disc = (m == 0); cfg_sw_sel = (m != 1); cfg_auto = (m != 2);
            b = req_cnt;
            @(negedge clk) reg_done = 1'b1;
            @(negedge clk) reg_done = 1'b0;
            settle();
            chk("R8", req_cnt - b, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule